// File: doc/BRIEF.md
# Dual-mode serial EEPROM interface controller

This block is the front end of a small serial EEPROM that can be used in two ways. At reset it is a transmit-only streamer. It counts rising edges of a dedicated video clock and sends its stored bytes out on the data line, most significant bit first. Its address starts at zero, wraps at the top of the array, and continues without end. The first nine video-clock pulses only synchronise the block, and the data line stays released during them. Each streamed byte is followed by one released slot.

A falling edge on the two-wire clock takes the block out of streaming. In the sticky variant (`RETURN_EN` = 0) the block becomes a two-wire slave and stays one until reset. In the returning variant (`RETURN_EN` = 1) it first waits in a transition state. A START condition there makes it a slave. If no START arrives within `TIMEOUT` video-clock rising edges, it goes back to streaming and resumes at the slot where it stopped. In slave mode it decodes a device-select byte. It then takes a word address and data bytes for writes, or streams bytes for reads. The memory is a register array that holds a fixed pattern at reset.

All inputs are levels that are already synchronised to `clk`. The block detects edges by comparing each input with its value from the previous cycle. The data line is open-drain: the block only ever pulls it low.

Top module: `dual_mode_eeprom_if`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (streaming) and `sda_low_o` is 0. Encodings: 2'b00 streaming, 2'b01 transition, 2'b10 two-wire slave.
- R2: In streaming mode, `sda_low_o` stays 0 during the first nine rising edges of `vclk_i` after reset.
- R3: On the tenth rising edge of `vclk_i`, the block presents bit 7 of byte 00h. At reset, byte n holds n XOR 5Ah. A 0 bit pulls the line low and a 1 bit releases it.
- R4: After that, each rising edge of `vclk_i` presents the next slot. A byte takes nine slots: bits 7 down to 0, then one released slot. The address then advances by one, and the byte at address 127 is followed by byte 00h.
- R5: A falling edge of `scl_i` in streaming mode releases the line. It sets `mode_o` to 2'b10 when `RETURN_EN`=0 and to 2'b01 when `RETURN_EN`=1.
- R6: With `RETURN_EN`=0, two-wire mode persists through STOP conditions and `vclk_i` activity until reset. In that mode `vclk_i` never drives the line.
- R7: In the transition state the line is released. A START (`sda_i` falls while `scl_i` is high) gives mode 2'b10. After `TIMEOUT` rising edges of `vclk_i` without a START, the mode returns to 2'b00, and the next rising edge of `vclk_i` continues the stream at the interrupted slot.
- R8: A device-select byte (MSB first) is acknowledged by pulling the line low during the ninth `scl_i` pulse only if bits 7:4 are 1010. When `STRICT_SEL`=1, bits 3:1 must also be 000. Bit 0 = 1 means read.
- R9: After a write select, the first byte sets the word address. Each following byte is stored at the current address, which then advances. Every byte is acknowledged.
- R10: After a read select, bytes are sent MSB first starting at the current address. The address advances after each byte. Another byte follows when the master acknowledges, and the line is released when the master does not.
- R11: With `RETURN_EN`=1, a STOP in two-wire mode sets `mode_o` back to 2'b01 and restarts the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vclk_i | input | 1 | Synchronised video-clock level for streaming |
| scl_i | input | 1 | Synchronised two-wire clock level |
| sda_i | input | 1 | Synchronised data line level |
| sda_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| mode_o | output | 2 | Current mode: 00 streaming, 01 transition, 10 two-wire |

## Verification
Most wrong internal states in this block show up on the data line within one video-clock slot. A wrong init count shifts the whole stream by a slot. A wrong bit index or address step corrupts the next byte. A missed wrap shows when address 127 is followed by anything other than byte 00h. Errors in mode tracking show on `mode_o` on the cycle after the triggering edge, while the timeout appears only on the exact `TIMEOUT`-th pulse. Faults in the slave state machine surface as a missing or extra acknowledge on the ninth clock, or as a wrong read-back byte.

// File: rtl/dual_mode_eeprom_if.sv
module dual_mode_eeprom_if #(
  parameter int DEPTH       = 128,
  parameter int INIT_PULSES = 9,
  parameter int TIMEOUT     = 16,
  parameter bit RETURN_EN   = 1'b0,
  parameter bit STRICT_SEL  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vclk_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_low_o,
  output logic [1:0] mode_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = $clog2(INIT_PULSES + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [1:0] M_TX = 2'b00, M_TRN = 2'b01, M_TWI = 2'b10;

  typedef enum logic [3:0] {I_IDLE, I_DEV, I_DACK, I_ADR, I_AACK, I_WR, I_WACK, I_RD, I_RACK} ist_t;

  logic          vclk_q, scl_q, sda_q;
  logic [1:0]    mode;
  logic [IW-1:0] init_cnt;
  logic [3:0]    tx_bit;
  logic [AW-1:0] tx_addr, rw_addr;
  logic [TW-1:0] tmr;
  ist_t          ist;
  logic [7:0]    sh;
  logic [3:0]    bcnt;
  logic          mack, sda_low;
  logic [7:0]    mem [DEPTH];

  logic vrise, sfall, srise, start, stop, init_done, sel_ok;
  logic [7:0] cur, rd_byte;

  assign vrise     = vclk_i & ~vclk_q;
  assign sfall     = scl_q & ~scl_i;
  assign srise     = ~scl_q & scl_i;
  assign start     = scl_i & scl_q & sda_q & ~sda_i;
  assign stop      = scl_i & scl_q & ~sda_q & sda_i;
  assign init_done = (init_cnt == IW'(INIT_PULSES));
  assign sel_ok    = (sh[7:4] == 4'b1010) && (!STRICT_SEL || sh[3:1] == 3'b000);
  assign cur       = mem[tx_addr];
  assign rd_byte   = mem[rw_addr];
  assign sda_low_o = sda_low;
  assign mode_o    = mode;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vclk_q   <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      mode     <= M_TX;
      init_cnt <= '0;
      tx_bit   <= '0;
      tx_addr  <= '0;
      rw_addr  <= '0;
      tmr      <= '0;
      ist      <= I_IDLE;
      sh       <= '0;
      bcnt     <= '0;
      mack     <= 1'b0;
      sda_low  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else begin
      vclk_q <= vclk_i;
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      case (mode)
        M_TX: begin
          if (sfall) begin
            mode    <= RETURN_EN ? M_TRN : M_TWI;
            tmr     <= '0;
            ist     <= I_IDLE;
            sda_low <= 1'b0;
          end else if (vrise) begin
            if (!init_done) init_cnt <= init_cnt + 1'b1;
            else begin
              sda_low <= (tx_bit != 4'd8) && !cur[3'd7 - tx_bit[2:0]];
              if (tx_bit == 4'd8) begin
                tx_bit  <= '0;
                tx_addr <= nxt(tx_addr);
              end else tx_bit <= tx_bit + 1'b1;
            end
          end
        end
        M_TRN: begin
          if (start) begin
            mode <= M_TWI;
            ist  <= I_DEV;
            bcnt <= '0;
          end else if (vrise) begin
            if (tmr == TW'(TIMEOUT - 1)) mode <= M_TX;
            else tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (start) begin
            ist     <= I_DEV;
            bcnt    <= '0;
            sda_low <= 1'b0;
          end else if (stop) begin
            ist     <= I_IDLE;
            sda_low <= 1'b0;
            if (RETURN_EN) begin
              mode <= M_TRN;
              tmr  <= '0;
            end
          end else begin
            case (ist)
              I_DEV, I_ADR, I_WR: begin
                if (srise) begin
                  sh   <= {sh[6:0], sda_i};
                  bcnt <= bcnt + 1'b1;
                end else if (sfall && bcnt == 4'd8) begin
                  bcnt <= '0;
                  if (ist == I_DEV) begin
                    if (sel_ok) begin
                      sda_low <= 1'b1;
                      ist     <= I_DACK;
                    end else ist <= I_IDLE;
                  end else if (ist == I_ADR) begin
                    rw_addr <= AW'(sh);
                    sda_low <= 1'b1;
                    ist     <= I_AACK;
                  end else begin
                    mem[rw_addr] <= sh;
                    rw_addr      <= nxt(rw_addr);
                    sda_low      <= 1'b1;
                    ist          <= I_WACK;
                  end
                end
              end
              I_DACK: begin
                if (sfall) begin
                  if (sh[0]) begin
                    sh      <= rd_byte;
                    sda_low <= ~rd_byte[7];
                    bcnt    <= 4'd1;
                    ist     <= I_RD;
                  end else begin
                    sda_low <= 1'b0;
                    ist     <= I_ADR;
                  end
                end
              end
              I_AACK, I_WACK: begin
                if (sfall) begin
                  sda_low <= 1'b0;
                  ist     <= I_WR;
                end
              end
              I_RD: begin
                if (sfall) begin
                  if (bcnt == 4'd8) begin
                    sda_low <= 1'b0;
                    bcnt    <= '0;
                    rw_addr <= nxt(rw_addr);
                    ist     <= I_RACK;
                  end else begin
                    sda_low <= ~sh[6];
                    sh      <= {sh[6:0], 1'b0};
                    bcnt    <= bcnt + 1'b1;
                  end
                end
              end
              I_RACK: begin
                if (srise) mack <= ~sda_i;
                else if (sfall) begin
                  if (mack) begin
                    sh      <= rd_byte;
                    sda_low <= ~rd_byte[7];
                    bcnt    <= 4'd1;
                    ist     <= I_RD;
                  end else ist <= I_IDLE;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TX && !init_done) |-> !sda_low); // R2
  AST_GAP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TX && vrise && !sfall && init_done && tx_bit == 4'd8) |=> !sda_low); // R4
  AST_LEAVE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TX && sfall) |=> (mode != M_TX && !sda_low)); // R5
  AST_STICKY_TWI: assert property (@(posedge clk) disable iff (!rst_n)
    (!RETURN_EN && mode == M_TWI) |=> (mode == M_TWI)); // R6
  AST_TRN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TRN) |-> !sda_low); // R7
  AST_STOP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (RETURN_EN && mode == M_TWI && stop && !start) |=> (mode == M_TRN)); // R11
endmodule

// File: tb/dual_mode_eeprom_if_tb.sv
module dual_mode_eeprom_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RET_TO = 6;
  localparam int NSLOTS = 128 * 9 + 3;
  localparam logic [9:0] SEL_TAB [8] = '{
    {8'hA0, 1'b1, 1'b1}, {8'hAE, 1'b1, 1'b0}, {8'hA2, 1'b1, 1'b0}, {8'hAA, 1'b1, 1'b0},
    {8'hB0, 1'b0, 1'b0}, {8'h20, 1'b0, 1'b0}, {8'hE0, 1'b0, 1'b0}, {8'hAC, 1'b1, 1'b0}};

  logic clk = 1'b0, rst_n = 1'b0, vclk = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic low_a, low_b, sda_a, sda_b;
  logic [1:0] mode_a, mode_b;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign sda_a = m_sda & ~low_a;
  assign sda_b = m_sda & ~low_b;

  dual_mode_eeprom_if u_dut (.clk(clk), .rst_n(rst_n), .vclk_i(vclk), .scl_i(scl),
    .sda_i(sda_a), .sda_low_o(low_a), .mode_o(mode_a));
  dual_mode_eeprom_if #(.TIMEOUT(RET_TO), .RETURN_EN(1'b1), .STRICT_SEL(1'b1)) u_dut_ret (
    .clk(clk), .rst_n(rst_n), .vclk_i(vclk), .scl_i(scl),
    .sda_i(sda_b), .sda_low_o(low_b), .mode_o(mode_b));

  function automatic logic [7:0] pat(int a);
    return 8'(a) ^ 8'h5A;
  endfunction
  function automatic logic exp_slot(int s);
    logic [7:0] b = pat((s / 9) % 128);
    return (s % 9 == 8) ? 1'b0 : ~b[7 - (s % 9)];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic vpulse();
    vclk = 1'b1; tick(3);
  endtask
  task automatic vdone();
    vclk = 1'b0; tick(3);
  endtask
  task automatic i2c_start();
    if (!scl) begin m_sda = 1'b1; tick(4); scl = 1'b1; tick(4); end
    m_sda = 1'b0; tick(4); scl = 1'b0; tick(4);
  endtask
  task automatic i2c_stop();
    m_sda = 1'b0; tick(4); scl = 1'b1; tick(4); m_sda = 1'b1; tick(4);
  endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(4); scl = 1'b1; tick(4); scl = 1'b0; tick(4);
    end
    m_sda = 1'b1; tick(4);
  endtask
  task automatic ack_clk(input string req, input logic ea, input logic eb);
    chk(req, low_a, ea);
    chk(req, low_b, eb);
    scl = 1'b1; tick(4); scl = 1'b0; tick(4);
  endtask
  task automatic read_byte(input logic ack, output logic [7:0] ba, output logic [7:0] bb);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; scl = 1'b1; tick(4);
      ba[i] = sda_a; bb[i] = sda_b;
      scl = 1'b0; tick(4);
    end
    m_sda = ~ack; tick(2); scl = 1'b1; tick(4); scl = 1'b0; tick(4); m_sda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] ra, rb;
    tick(3); rst_n = 1'b1; tick(2);
    chk("R1 mode", mode_a, 2'b00); chk("R1 mode ret", mode_b, 2'b00);
    chk("R1 sda", low_a, 1'b0);    chk("R1 sda ret", low_b, 1'b0);

    for (int p = 0; p < 9; p++) begin
      vpulse(); chk("R2 init quiet", low_a, 1'b0); chk("R2 init quiet ret", low_b, 1'b0); vdone();
    end
    for (int s = 0; s < NSLOTS; s++) begin
      vpulse();
      if (s == 0) chk("R3 first bit", low_a, exp_slot(s));
      else if (s >= 128 * 9) chk("R4 wrap", low_a, exp_slot(s));
      else chk("R4 stream", low_a, exp_slot(s));
      chk("R4 stream ret", low_b, exp_slot(s));
      vdone();
    end

    scl = 1'b0; tick(4);
    chk("R5 sticky entry", mode_a, 2'b10); chk("R5 returning entry", mode_b, 2'b01);
    chk("R5 release", low_a, 1'b0);        chk("R5 release ret", low_b, 1'b0);

    for (int p = 1; p <= RET_TO; p++) begin
      vpulse();
      chk("R7 timeout mode", mode_b, (p == RET_TO) ? 2'b00 : 2'b01);
      chk("R7 quiet", low_b, 1'b0);
      chk("R6 vclk ignored", low_a, 1'b0);
      chk("R6 mode kept", mode_a, 2'b10);
      vdone();
    end
    for (int s = NSLOTS; s < NSLOTS + 3; s++) begin
      vpulse(); chk("R7 stream resumes", low_b, exp_slot(s)); vdone();
    end
    scl = 1'b1; tick(4); scl = 1'b0; tick(4);
    chk("R5 re-entry", mode_b, 2'b01);
    i2c_start();
    chk("R7 start to two-wire", mode_b, 2'b10);

    foreach (SEL_TAB[k]) begin
      i2c_start();
      send_byte(SEL_TAB[k][9:2]);
      ack_clk("R8 select ack", SEL_TAB[k][1], SEL_TAB[k][0]);
      i2c_stop();
      chk("R11 stop to transition", mode_b, 2'b01);
      chk("R6 stop keeps two-wire", mode_a, 2'b10);
    end

    i2c_start(); send_byte(8'hA0); ack_clk("R8 write select", 1'b1, 1'b1);
    send_byte(8'h10); ack_clk("R9 address ack", 1'b1, 1'b1);
    send_byte(8'h3C); ack_clk("R9 data ack", 1'b1, 1'b1);
    send_byte(8'hC3); ack_clk("R9 data ack", 1'b1, 1'b1);
    i2c_stop();

    i2c_start(); send_byte(8'hA0); ack_clk("R9 write select", 1'b1, 1'b1);
    send_byte(8'h10); ack_clk("R9 address ack", 1'b1, 1'b1);
    i2c_start(); send_byte(8'hA1); ack_clk("R8 read select", 1'b1, 1'b1);
    read_byte(1'b1, ra, rb); chk("R10 R9 read 10h", ra, 8'h3C); chk("R10 R9 read 10h ret", rb, 8'h3C);
    read_byte(1'b1, ra, rb); chk("R10 R9 read 11h", ra, 8'hC3); chk("R10 R9 read 11h ret", rb, 8'hC3);
    read_byte(1'b0, ra, rb); chk("R10 read 12h", ra, pat(8'h12)); chk("R10 read 12h ret", rb, pat(8'h12));
    chk("R10 nack release", low_a, 1'b0); chk("R10 nack release ret", low_b, 1'b0);
    i2c_stop();
    chk("R11 final stop", mode_b, 2'b01); chk("R6 final", mode_a, 2'b10);

    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);
    chk("R6 reset clears two-wire", mode_a, 2'b00); chk("R1 reset again", low_a, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule